// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Bank

This block holds the control state for a bank of byte-wide general-purpose I/O ports and exposes it on an 8-bit register bus. Each port keeps six byte registers:

- a read-only view of the pin levels;
- the level to drive;
- a per-pin output drive enable;
- a pull-up request;
- a Schmitt-trigger request;
- a per-pin input enable.

The drive, pull-up, Schmitt and input-enable bits leave the block as pad-control outputs. A further group of registers selects, with a 2-bit code per pin, which peripheral function each pin is routed to.

External pin levels pass through a two-flop synchronizer. A pin's level is only visible to software while that pin's input enable is set. Pins absent from a given configuration are described by a per-pin mask. Whole ports can be removed through a count parameter. Bits of absent pins and ports read as zero, drive zero and ignore writes.

All registers live in the 0x52xx page. Port p occupies 0x5200 + 0x10·p. Function selects occupy 0x52A0 upward, two bytes per port. Writes take effect on the rising clock edge. Reads are combinational from the address.

Top module: `gpio_bank`

## Requirements
- R1: Port p's registers decode at 0x5200 + 0x10·p with these offsets: 0x0 pin levels, 0x1 drive level, 0x2 drive enable, 0x3 pull-up, 0x4 Schmitt, 0xA input enable. A write to any offset other than 0x0 reads back as the written byte, masked to implemented pins.
- R2: Reading offset 0x0 returns, for each pin whose input-enable bit is 1, the synchronized pin level (1 high, 0 low). This holds even while that pin's drive enable is 1.
- R3: Reading offset 0x0 returns 0 in every bit whose input-enable bit is 0.
- R4: Offset 0x0 is read-only: a write there changes no register and no output.
- R5: A level applied to `pin_in` before a rising edge is not visible after that edge. It is visible in the offset-0x0 read after the following edge (two-flop synchronizer).
- R6: Bits of pins cleared in `PIN_MASK` read as 0 in every register, drive 0 on every pad output, and discard written ones.
- R7: The function select of port p is at 0x52A0 + 2p for pins 3:0 and 0x52A1 + 2p for pins 7:4. Pin n of a group uses bits [2n+1:2n] of its byte. The same code appears on `pin_fsel[16p + 2·pin +: 2]`.
- R8: Ports numbered `PORTS_FITTED` and above have no registers. Their addresses read 0, writes to them are ignored, and their outputs stay 0.
- R9: Reset clears drive level, drive enable and function select. Pull-up, Schmitt and input enable load `PU_RST`, `SM_RST` and `IE_RST`, each masked to implemented pins.
- R10: Undecoded addresses read 0, and writes to them change no register. Undecoded addresses are: outside page 0x52, unused offsets within a port, port slots past `NUM_PORTS`, and select bytes past the last port.
- R11: `pin_out`, `pin_oe`, `pin_pu`, `pin_smt` and `pin_ie` show the register contents in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 8·NUM_PORTS | External pin levels, port p at bits [8p+7:8p] |
| pin_out | output | 8·NUM_PORTS | Drive level per pin |
| pin_oe | output | 8·NUM_PORTS | Drive enable per pin |
| pin_pu | output | 8·NUM_PORTS | Pull-up request per pin |
| pin_smt | output | 8·NUM_PORTS | Schmitt-trigger request per pin |
| pin_ie | output | 8·NUM_PORTS | Input enable per pin |
| pin_fsel | output | 16·NUM_PORTS | 2-bit function code per pin, port p at [16p+15:16p] |

## Verification
The pin-level read is tried with the following input-enable patterns:
- all enables clear, which separates gating from the raw synchronizer output;
- all enables set, with and without drive enable, which shows that drive does not hide the input;
- a half-byte enable pattern against a mixed pin pattern, which catches a swapped or inverted gate.

Writes are aimed at the read-only offset, at masked pins, at a removed port, and at holes in the page. Each exposes a decode or mask that leaks. A single pin step timed against the clock edges separates a two-stage synchronizer from a one-stage one. Function-select bytes written with a distinct code in every pin slot catch a misplaced field.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NUM_PORTS = 6,
  parameter int PORTS_FITTED = 6,
  parameter logic [NUM_PORTS*8-1:0] PIN_MASK = {1'b0, {(NUM_PORTS*8-1){1'b1}}},
  parameter logic [7:0] PU_RST = 8'h00,
  parameter logic [7:0] SM_RST = 8'hFF,
  parameter logic [7:0] IE_RST = 8'h00
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_we,
  input  logic [15:0]              bus_addr,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               bus_rdata,
  input  logic [NUM_PORTS*8-1:0]   pin_in,
  output logic [NUM_PORTS*8-1:0]   pin_out,
  output logic [NUM_PORTS*8-1:0]   pin_oe,
  output logic [NUM_PORTS*8-1:0]   pin_pu,
  output logic [NUM_PORTS*8-1:0]   pin_smt,
  output logic [NUM_PORTS*8-1:0]   pin_ie,
  output logic [NUM_PORTS*16-1:0]  pin_fsel
);
  localparam logic [7:0] PAGE   = 8'h52;
  localparam logic [3:0] FS_ROW = 4'hA;

  function automatic logic [15:0] widen(input logic [7:0] m);
    for (int i = 0; i < 8; i++) widen[2*i +: 2] = {2{m[i]}};
  endfunction

  logic [NUM_PORTS*8-1:0] in_view;
  logic page_hit;
  assign page_hit = (bus_addr[15:8] == PAGE);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [3:0]  IDX = 4'(p);
    localparam logic [7:0]  M   = PIN_MASK[p*8 +: 8];
    localparam logic [15:0] FM  = widen(M);

    if (p < PORTS_FITTED) begin : g_fit
      logic [7:0]  s1, s2, out_q, oe_q, pu_q, sm_q, ie_q;
      logic [15:0] fs_q;
      logic        reg_wr, fs_wr;

      assign reg_wr = bus_we && page_hit && (bus_addr[7:4] == IDX);
      assign fs_wr  = bus_we && page_hit && (bus_addr[7:4] == FS_ROW)
                      && (bus_addr[3:1] == IDX[2:0]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1 <= '0; s2 <= '0;
          out_q <= '0; oe_q <= '0; fs_q <= '0;
          pu_q <= PU_RST & M; sm_q <= SM_RST & M; ie_q <= IE_RST & M;
        end else begin
          s1 <= pin_in[p*8 +: 8] & M;
          s2 <= s1;
          if (reg_wr) begin
            case (bus_addr[3:0])
              4'h1: out_q <= bus_wdata & M;
              4'h2: oe_q  <= bus_wdata & M;
              4'h3: pu_q  <= bus_wdata & M;
              4'h4: sm_q  <= bus_wdata & M;
              4'hA: ie_q  <= bus_wdata & M;
              default: ;
            endcase
          end
          if (fs_wr) begin
            if (bus_addr[0]) fs_q[15:8] <= bus_wdata & FM[15:8];
            else             fs_q[7:0]  <= bus_wdata & FM[7:0];
          end
        end
      end

      assign in_view[p*8 +: 8]   = s2 & ie_q;
      assign pin_out[p*8 +: 8]   = out_q;
      assign pin_oe[p*8 +: 8]    = oe_q;
      assign pin_pu[p*8 +: 8]    = pu_q;
      assign pin_smt[p*8 +: 8]   = sm_q;
      assign pin_ie[p*8 +: 8]    = ie_q;
      assign pin_fsel[p*16 +: 16] = fs_q;
    end else begin : g_absent
      assign in_view[p*8 +: 8]   = '0;
      assign pin_out[p*8 +: 8]   = '0;
      assign pin_oe[p*8 +: 8]    = '0;
      assign pin_pu[p*8 +: 8]    = '0;
      assign pin_smt[p*8 +: 8]   = '0;
      assign pin_ie[p*8 +: 8]    = '0;
      assign pin_fsel[p*16 +: 16] = '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (page_hit && bus_addr[7:4] == 4'(p)) begin
        case (bus_addr[3:0])
          4'h0: bus_rdata = in_view[p*8 +: 8];
          4'h1: bus_rdata = pin_out[p*8 +: 8];
          4'h2: bus_rdata = pin_oe[p*8 +: 8];
          4'h3: bus_rdata = pin_pu[p*8 +: 8];
          4'h4: bus_rdata = pin_smt[p*8 +: 8];
          4'hA: bus_rdata = pin_ie[p*8 +: 8];
          default: ;
        endcase
      end
      if (page_hit && bus_addr[7:4] == FS_ROW && bus_addr[3:0] == 4'(2*p))
        bus_rdata = pin_fsel[p*16 +: 8];
      if (page_hit && bus_addr[7:4] == FS_ROW && bus_addr[3:0] == 4'(2*p+1))
        bus_rdata = pin_fsel[p*16+8 +: 8];
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PORTS = 6,
  parameter int PORTS_FITTED = 6,
  parameter logic [NUM_PORTS*8-1:0] PIN_MASK = {1'b0, {(NUM_PORTS*8-1){1'b1}}}
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_we,
  input logic [15:0]             bus_addr,
  input logic [7:0]              bus_wdata,
  input logic [7:0]              bus_rdata,
  input logic [NUM_PORTS*8-1:0]  pin_out,
  input logic [NUM_PORTS*8-1:0]  pin_oe,
  input logic [NUM_PORTS*8-1:0]  pin_pu,
  input logic [NUM_PORTS*8-1:0]  pin_smt,
  input logic [NUM_PORTS*8-1:0]  pin_ie,
  input logic [NUM_PORTS*16-1:0] pin_fsel
);
  function automatic logic [NUM_PORTS*8-1:0] fit_mask();
    for (int p = 0; p < NUM_PORTS; p++)
      fit_mask[p*8 +: 8] = (p < PORTS_FITTED) ? 8'hFF : 8'h00;
  endfunction

  function automatic logic [NUM_PORTS*16-1:0] pair(input logic [NUM_PORTS*8-1:0] m);
    for (int i = 0; i < NUM_PORTS*8; i++) pair[2*i +: 2] = {2{m[i]}};
  endfunction

  localparam logic [NUM_PORTS*8-1:0]  FIT   = fit_mask();
  localparam logic [NUM_PORTS*16-1:0] PM16  = pair(PIN_MASK);
  localparam logic [NUM_PORTS*16-1:0] FIT16 = pair(FIT);

  logic [NUM_PORTS*8-1:0] any_pad;
  assign any_pad = pin_out | pin_oe | pin_pu | pin_smt | pin_ie;

  p_masked_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((any_pad & ~PIN_MASK) == '0) && ((pin_fsel & ~PM16) == '0));

  p_absent_ports_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((any_pad & ~FIT) == '0) && ((pin_fsel & ~FIT16) == '0));

  p_in_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 16'h5200) |-> ((bus_rdata & ~pin_ie[7:0]) == 8'h00));

  p_input_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 16'h5200) |=>
      ($stable(pin_out) && $stable(pin_oe) && $stable(pin_pu)
       && $stable(pin_smt) && $stable(pin_ie) && $stable(pin_fsel)));

  p_undecoded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:8] != 8'h52) |-> (bus_rdata == 8'h00));

  p_out_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 16'h5201) |=>
      (pin_out[7:0] == ($past(bus_wdata) & PIN_MASK[7:0])));

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0 && pin_fsel == '0));
endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .PORTS_FITTED(PORTS_FITTED), .PIN_MASK(PIN_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_smt(pin_smt), .pin_ie(pin_ie),
  .pin_fsel(pin_fsel)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  localparam int NP = 6;
  localparam logic [NP*8-1:0] MASK = 48'h7F_FF_0F_FF_FF_FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [NP*8-1:0] pin_in = 48'hC3_5A_F0_96_3C_A5;
  logic [NP*8-1:0] pin_out, pin_oe, pin_pu, pin_smt, pin_ie;
  logic [NP*16-1:0] pin_fsel;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  gpio_bank #(.NUM_PORTS(NP), .PORTS_FITTED(5), .PIN_MASK(MASK),
              .PU_RST(8'hA5), .SM_RST(8'hFF), .IE_RST(8'h00)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_smt(pin_smt),
    .pin_ie(pin_ie), .pin_fsel(pin_fsel));

  // {we, addr, wdata, expected read, requirement number}
  localparam int NV = 34;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0,16'h5201,8'h00,8'h00,8'd9},   // R9 drive level cleared
    {1'b0,16'h5203,8'h00,8'hA5,8'd9},   // R9 pull-up default
    {1'b0,16'h5233,8'h00,8'h05,8'd9},   // R9 default masked (port 3)
    {1'b0,16'h5204,8'h00,8'hFF,8'd9},   // R9 Schmitt default
    {1'b0,16'h5234,8'h00,8'h0F,8'd9},   // R9 Schmitt masked
    {1'b0,16'h520A,8'h00,8'h00,8'd9},   // R9 input enable default
    {1'b0,16'h5200,8'h00,8'h00,8'd3},   // R3 gated off
    {1'b1,16'h5201,8'h5A,8'h5A,8'd1},   // R1 drive level
    {1'b1,16'h5212,8'hFF,8'hFF,8'd1},   // R1 drive enable port 1
    {1'b1,16'h5243,8'h3C,8'h3C,8'd1},   // R1 pull-up port 4
    {1'b1,16'h520A,8'hFF,8'hFF,8'd2},   // R2 enable inputs
    {1'b0,16'h5200,8'h00,8'hA5,8'd2},   // R2 pin levels
    {1'b1,16'h5202,8'h0F,8'h0F,8'd2},   // R2 drive on
    {1'b0,16'h5200,8'h00,8'hA5,8'd2},   // R2 still readable
    {1'b1,16'h521A,8'h0F,8'h0F,8'd3},   // R3 half enabled
    {1'b0,16'h5210,8'h00,8'h0C,8'd3},   // R3 upper half gated
    {1'b1,16'h5200,8'h00,8'hA5,8'd4},   // R4 write ignored
    {1'b1,16'h5231,8'hFF,8'h0F,8'd6},   // R6 masked write
    {1'b1,16'h523A,8'hFF,8'h0F,8'd6},   // R6 masked enable
    {1'b0,16'h5230,8'h00,8'h00,8'd6},   // R6 masked input
    {1'b1,16'h5251,8'hFF,8'h00,8'd8},   // R8 removed port
    {1'b0,16'h5250,8'h00,8'h00,8'd8},   // R8 removed input
    {1'b1,16'h52AA,8'hFF,8'h00,8'd8},   // R8 removed select
    {1'b1,16'h52A0,8'hE4,8'hE4,8'd7},   // R7 low group
    {1'b1,16'h52A1,8'h1B,8'h1B,8'd7},   // R7 high group
    {1'b1,16'h52A6,8'hFF,8'hFF,8'd7},   // R7 port 3 low
    {1'b1,16'h52A7,8'hFF,8'h00,8'd7},   // R7 port 3 high masked
    {1'b1,16'h5205,8'h77,8'h00,8'd10},  // R10 hole offset
    {1'b1,16'h5301,8'h00,8'h00,8'd10},  // R10 other page
    {1'b0,16'h5201,8'h00,8'h5A,8'd10},  // R10 no side effect
    {1'b0,16'h5260,8'h00,8'h00,8'd10},  // R10 port slot past end
    {1'b0,16'h52AC,8'h00,8'h00,8'd10},  // R10 select past end
    {1'b1,16'h524A,8'hFF,8'hFF,8'd2},   // R2 port 4 enable
    {1'b0,16'h5240,8'h00,8'h5A,8'd2}    // R2 port 4 levels
  };

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][40], VEC[i][39:24], VEC[i][23:16]);
      check({8'h00, bus_rdata}, {8'h00, VEC[i][15:8]}, $sformatf("R%0d vec %0d", VEC[i][7:0], i));
    end

    // R11 pad outputs follow registers
    check({8'h00, pin_out[7:0]}, 16'h005A, "R11 pin_out port0");
    check({8'h00, pin_oe[15:8]}, 16'h00FF, "R11 pin_oe port1");
    check({8'h00, pin_pu[39:32]}, 16'h003C, "R11 pin_pu port4");
    // R7 per-pin field placement
    check({14'd0, pin_fsel[1:0]}, 16'd0, "R7 pin0 code");
    check({14'd0, pin_fsel[7:6]}, 16'd3, "R7 pin3 code");
    check({14'd0, pin_fsel[9:8]}, 16'd3, "R7 pin4 code");
    check({14'd0, pin_fsel[15:14]}, 16'd0, "R7 pin7 code");
    check(pin_fsel[63:48], 16'h00FF, "R7 port3 select masked");
    // R8 removed port outputs
    check({8'h00, pin_out[47:40] | pin_ie[47:40]}, 16'h0000, "R8 port5 pads");

    // R5 synchronizer timing
    bus_addr = 16'h5200;
    @(negedge clk);
    pin_in[7:0] = 8'h5A;
    @(posedge clk); #1;
    check({8'h00, bus_rdata}, 16'h00A5, "R5 after first edge");
    @(posedge clk); #1;
    check({8'h00, bus_rdata}, 16'h005A, "R5 after second edge");

    // R9 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, 16'h5201, 8'h00); check({8'h00, bus_rdata}, 16'h0000, "R9 drive level");
    access(1'b0, 16'h5212, 8'h00); check({8'h00, bus_rdata}, 16'h0000, "R9 drive enable");
    access(1'b0, 16'h52A0, 8'h00); check({8'h00, bus_rdata}, 16'h0000, "R9 select");
    access(1'b0, 16'h520A, 8'h00); check({8'h00, bus_rdata}, 16'h0000, "R9 input enable");
    access(1'b0, 16'h5243, 8'h00); check({8'h00, bus_rdata}, 16'h00A5, "R9 pull-up");
    access(1'b0, 16'h5200, 8'h00); check({8'h00, bus_rdata}, 16'h0000, "R3 after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule